// File: doc/BRIEF.md
# Switch-on-miss thread controller

This block steers an in-order pipeline that holds several hardware thread contexts but runs only one of them at a time. Software sees each context as its own, slower, virtual CPU. The running thread keeps the pipeline until it takes a long-latency cache miss. On that miss the controller flushes every instruction in flight and hands the pipeline to another context. Fetch then stays off for a fixed penalty before the new thread restarts.

For each context the controller holds the restart PC, which is the PC of the oldest instruction that has not yet retired. It also holds a waiting flag that is set by that context's miss and cleared by its miss-return pulse. If every context is waiting, the pipeline sits idle until a return arrives. The block drives the active thread ID, a one-cycle flush request, a fetch enable, and a load strobe with the PC the fetch unit restarts from.

Top module: `miss_switch_ctrl`

## Requirements
- R1: While reset is asserted, `active_tid` is 0, `fetch_en` is 1, `flush` is 0, `pc_load` is 1 and `resume_pc` equals `BOOT_BASE`.
- R2: When `miss_valid` is high with `miss_tid` equal to `active_tid` while `fetch_en` is 1, the next cycle shows `flush` high for exactly one cycle. In that same cycle `active_tid` moves to the first non-waiting context after the current one in ascending, wrapping order.
- R3: `fetch_en` is 0 for exactly `PENALTY` cycles (default 4), counted from the cycle in which `flush` is high. In the first cycle after that window `fetch_en` returns to 1, `pc_load` is 1 for one cycle, and `resume_pc` is the restart PC of the context now active.
- R4: A context's restart PC is its boot PC, or the last `retire_next_pc` accepted while that context ran. It is saved at the switch. A retirement in the switch cycle, or while `fetch_en` is 0, is discarded.
- R5: A miss whose `miss_tid` is not the running context causes no flush and no switch.
- R6: A context stays waiting from its own switch until its `fill_done` bit is seen. A `fill_done` pulse for a context that is not waiting has no effect.
- R7: If no other context is ready at a switch, `active_tid` stays unchanged and the penalty still runs. `fetch_en` then stays 0 until some context's `fill_done` pulse. Fetch restarts two cycles after that pulse, on the context that returned.
- R8: During a penalty window, a miss from the incoming context is held. When the window ends, a new flush and switch take place instead of a restart, and the PC saved for that context is the one it would have resumed at.
- R9: With default parameters there are two contexts (IDs 0 and 1) with boot PCs `BOOT_BASE` and `BOOT_BASE + BOOT_STRIDE` (0x1000 and 0x2000).
- R10: If several contexts are ready while idle, the first one after the current `active_tid` in wrapping order is chosen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Long-latency miss reported this cycle |
| miss_tid | input | TID_W | Context that took the miss |
| fill_done | input | NUM_CTX | Miss-return pulse, one bit per context |
| retire_valid | input | 1 | An instruction of the running context retired |
| retire_next_pc | input | PC_W | PC of the oldest unretired instruction after that retirement |
| active_tid | output | TID_W | Context that owns the pipeline |
| flush | output | 1 | One-cycle pipeline flush request |
| fetch_en | output | 1 | Fetch allowed |
| pc_load | output | 1 | Fetch must restart from `resume_pc` |
| resume_pc | output | PC_W | Restart PC of the active context |

## Verification
On every cycle, the in-module properties check the following:
- a miss from the running context produces a flush and stops fetch on the next cycle;
- a miss from any other context produces no flush;
- a flush lasts a single cycle;
- a rise of fetch comes with a PC load;
- a waiting flag holds until its return pulse;
- fetch never runs for a waiting context.

The exact penalty length, the saved and discarded restart PCs, the held miss inside a penalty window, the idle wait and the wrap-order choice between several ready contexts are visible only in the bench. There, a behavioural model is compared against the outputs each cycle, along with directed scenarios.

// File: rtl/miss_switch_pkg.sv
package miss_switch_pkg;

   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_PEN  = 2'd1,
      ST_IDLE = 2'd2
   } seq_state_e;

endpackage

// File: rtl/miss_switch_ctx_file.sv
module miss_switch_ctx_file #(
   parameter int                NUM_CTX     = 2,
   parameter int                TID_W       = 1,
   parameter int                PC_W        = 32,
   parameter logic [PC_W-1:0]   BOOT_BASE   = 'h1000,
   parameter logic [PC_W-1:0]   BOOT_STRIDE = 'h1000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 park_i,
   input  logic [TID_W-1:0]     park_tid_i,
   input  logic [PC_W-1:0]      park_pc_i,
   input  logic [NUM_CTX-1:0]   fill_done_i,
   input  logic [TID_W-1:0]     rd_tid_i,
   output logic [PC_W-1:0]      rd_pc_o,
   output logic [NUM_CTX-1:0]   waiting_o
);

   logic [PC_W-1:0] saved_q [NUM_CTX];

   for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
      logic hit_park;
      assign hit_park = park_i && (park_tid_i == TID_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            waiting_o[g] <= 1'b0;
            saved_q[g]   <= BOOT_BASE + BOOT_STRIDE * PC_W'(g);
         end else begin
            if (hit_park) begin
               waiting_o[g] <= 1'b1;
               saved_q[g]   <= park_pc_i;
            end else if (fill_done_i[g]) begin
               waiting_o[g] <= 1'b0;
            end
         end
      end

      // R6
      wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (waiting_o[g] && !fill_done_i[g]) |=> waiting_o[g]);
   end

   assign rd_pc_o = saved_q[rd_tid_i];

endmodule

// File: rtl/miss_switch_pick.sv
module miss_switch_pick #(
   parameter int NUM_CTX = 2,
   parameter int TID_W   = 1
) (
   input  logic [NUM_CTX-1:0] ready_i,
   input  logic [TID_W-1:0]   cur_i,
   input  logic               incl_cur_i,
   output logic               found_o,
   output logic [TID_W-1:0]   pick_o
);

   int best_d;
   int dist_d;

   always_comb begin
      found_o = 1'b0;
      pick_o  = cur_i;
      best_d  = NUM_CTX + 1;
      dist_d  = 0;
      for (int t = 0; t < NUM_CTX; t++) begin
         dist_d = (t - int'(cur_i) + NUM_CTX) % NUM_CTX;
         if (dist_d == 0) dist_d = NUM_CTX;
         if (ready_i[t] && (dist_d < NUM_CTX || incl_cur_i) && dist_d < best_d) begin
            best_d  = dist_d;
            pick_o  = TID_W'(t);
            found_o = 1'b1;
         end
      end
   end

endmodule

// File: rtl/miss_switch_seq.sv
module miss_switch_seq
   import miss_switch_pkg::*;
#(
   parameter int                NUM_CTX   = 2,
   parameter int                TID_W     = 1,
   parameter int                PC_W      = 32,
   parameter int                PENALTY   = 4,
   parameter logic [PC_W-1:0]   BOOT_BASE = 'h1000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 miss_valid_i,
   input  logic [TID_W-1:0]     miss_tid_i,
   input  logic                 retire_valid_i,
   input  logic [PC_W-1:0]      retire_next_pc_i,
   input  logic [NUM_CTX-1:0]   waiting_i,
   input  logic                 pick_found_i,
   input  logic [TID_W-1:0]     pick_tid_i,
   input  logic [PC_W-1:0]      pick_pc_i,
   output logic                 incl_cur_o,
   output logic                 park_o,
   output logic [TID_W-1:0]     park_tid_o,
   output logic [PC_W-1:0]      park_pc_o,
   output logic [TID_W-1:0]     active_tid_o,
   output logic                 flush_o,
   output logic                 fetch_en_o,
   output logic                 pc_load_o,
   output logic [PC_W-1:0]      resume_pc_o
);

   localparam int               CNT_W    = (PENALTY > 2) ? $clog2(PENALTY) : 1;
   localparam logic [CNT_W-1:0] PEN_LAST = CNT_W'(PENALTY - 1);

   seq_state_e        st_q,    st_d;
   logic [CNT_W-1:0]  cnt_q,   cnt_d;
   logic              pend_q,  pend_d;
   logic [TID_W-1:0]  act_q,   act_d;
   logic [PC_W-1:0]   track_q, track_d;
   logic              flush_q, flush_d;
   logic              load_q,  load_d;
   logic              hit;
   logic              do_sw;

   assign hit   = miss_valid_i && (miss_tid_i == act_q) && !waiting_i[act_q];
   assign do_sw = ((st_q == ST_RUN) && hit) ||
                  ((st_q == ST_PEN) && (cnt_q == '0) && (pend_q || hit));

   always_comb begin
      st_d    = st_q;
      cnt_d   = cnt_q;
      pend_d  = pend_q;
      act_d   = act_q;
      track_d = track_q;
      flush_d = 1'b0;
      load_d  = 1'b0;
      if (do_sw) begin
         st_d    = ST_PEN;
         cnt_d   = PEN_LAST;
         pend_d  = 1'b0;
         flush_d = 1'b1;
         if (pick_found_i) begin
            act_d   = pick_tid_i;
            track_d = pick_pc_i;
         end
      end else begin
         unique case (st_q)
            ST_RUN: begin
               if (retire_valid_i) track_d = retire_next_pc_i;
            end
            ST_PEN: begin
               if (cnt_q != '0) begin
                  cnt_d  = cnt_q - 1'b1;
                  pend_d = pend_q | hit;
               end else if (waiting_i[act_q]) begin
                  st_d = ST_IDLE;
               end else begin
                  st_d   = ST_RUN;
                  load_d = 1'b1;
               end
            end
            ST_IDLE: begin
               if (pick_found_i) begin
                  act_d   = pick_tid_i;
                  track_d = pick_pc_i;
                  st_d    = ST_RUN;
                  load_d  = 1'b1;
               end
            end
            default: st_d = ST_RUN;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_RUN;
         cnt_q   <= '0;
         pend_q  <= 1'b0;
         act_q   <= '0;
         track_q <= BOOT_BASE;
         flush_q <= 1'b0;
         load_q  <= 1'b1;
      end else begin
         st_q    <= st_d;
         cnt_q   <= cnt_d;
         pend_q  <= pend_d;
         act_q   <= act_d;
         track_q <= track_d;
         flush_q <= flush_d;
         load_q  <= load_d;
      end
   end

   assign incl_cur_o   = (st_q == ST_IDLE);
   assign park_o       = do_sw;
   assign park_tid_o   = act_q;
   assign park_pc_o    = track_q;
   assign active_tid_o = act_q;
   assign flush_o      = flush_q;
   assign fetch_en_o   = (st_q == ST_RUN);
   assign pc_load_o    = load_q;
   assign resume_pc_o  = track_q;

   // R2
   switch_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_en_o && miss_valid_i && miss_tid_i == active_tid_o) |=> (flush_o && !fetch_en_o));

   // R5
   foreign_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_en_o && miss_valid_i && miss_tid_i != active_tid_o) |=> !flush_o);

   // R3
   flush_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_o |=> !flush_o);

   // R3
   load_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fetch_en_o) |-> pc_load_o);

endmodule

// File: rtl/miss_switch_ctrl.sv
module miss_switch_ctrl #(
   parameter int                NUM_CTX     = 2,
   parameter int                TID_W       = $clog2(NUM_CTX),
   parameter int                PC_W        = 32,
   parameter int                PENALTY     = 4,
   parameter logic [PC_W-1:0]   BOOT_BASE   = 'h1000,
   parameter logic [PC_W-1:0]   BOOT_STRIDE = 'h1000
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 miss_valid,
   input  logic [TID_W-1:0]     miss_tid,
   input  logic [NUM_CTX-1:0]   fill_done,
   input  logic                 retire_valid,
   input  logic [PC_W-1:0]      retire_next_pc,
   output logic [TID_W-1:0]     active_tid,
   output logic                 flush,
   output logic                 fetch_en,
   output logic                 pc_load,
   output logic [PC_W-1:0]      resume_pc
);

   if (NUM_CTX < 2)                 $error("NUM_CTX must be at least 2");
   if (TID_W != $clog2(NUM_CTX))    $error("TID_W must equal clog2(NUM_CTX)");
   if (PENALTY < 2)                 $error("PENALTY must be at least 2");
   if (PC_W < 2)                    $error("PC_W too small");

   logic [NUM_CTX-1:0] waiting;
   logic               incl_cur;
   logic               pick_found;
   logic [TID_W-1:0]   pick_tid;
   logic [PC_W-1:0]    pick_pc;
   logic               park;
   logic [TID_W-1:0]   park_tid;
   logic [PC_W-1:0]    park_pc;

   miss_switch_ctx_file #(
      .NUM_CTX     (NUM_CTX),
      .TID_W       (TID_W),
      .PC_W        (PC_W),
      .BOOT_BASE   (BOOT_BASE),
      .BOOT_STRIDE (BOOT_STRIDE)
   ) u_ctx (
      .clk         (clk),
      .rst_n       (rst_n),
      .park_i      (park),
      .park_tid_i  (park_tid),
      .park_pc_i   (park_pc),
      .fill_done_i (fill_done),
      .rd_tid_i    (pick_tid),
      .rd_pc_o     (pick_pc),
      .waiting_o   (waiting)
   );

   miss_switch_pick #(
      .NUM_CTX    (NUM_CTX),
      .TID_W      (TID_W)
   ) u_pick (
      .ready_i    (~waiting),
      .cur_i      (active_tid),
      .incl_cur_i (incl_cur),
      .found_o    (pick_found),
      .pick_o     (pick_tid)
   );

   miss_switch_seq #(
      .NUM_CTX   (NUM_CTX),
      .TID_W     (TID_W),
      .PC_W      (PC_W),
      .PENALTY   (PENALTY),
      .BOOT_BASE (BOOT_BASE)
   ) u_seq (
      .clk              (clk),
      .rst_n            (rst_n),
      .miss_valid_i     (miss_valid),
      .miss_tid_i       (miss_tid),
      .retire_valid_i   (retire_valid),
      .retire_next_pc_i (retire_next_pc),
      .waiting_i        (waiting),
      .pick_found_i     (pick_found),
      .pick_tid_i       (pick_tid),
      .pick_pc_i        (pick_pc),
      .incl_cur_o       (incl_cur),
      .park_o           (park),
      .park_tid_o       (park_tid),
      .park_pc_o        (park_pc),
      .active_tid_o     (active_tid),
      .flush_o          (flush),
      .fetch_en_o       (fetch_en),
      .pc_load_o        (pc_load),
      .resume_pc_o      (resume_pc)
   );

   // R7
   ready_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_en |-> !waiting[active_tid]);

endmodule

// File: tb/miss_switch_ctrl_bench.sv
module miss_switch_ctrl_bench;

   localparam int          N    = 2;
   localparam int          P    = 4;
   localparam logic [31:0] BASE = 32'h1000;
   localparam logic [31:0] STR  = 32'h1000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        miss_valid = 1'b0;
   logic [0:0]  miss_tid = '0;
   logic [1:0]  fill_done = '0;
   logic        retire_valid = 1'b0;
   logic [31:0] retire_next_pc = '0;
   logic [0:0]  active_tid;
   logic        flush, fetch_en, pc_load;
   logic [31:0] resume_pc;

   int checks = 0;
   int errors = 0;
   int cyc = 0;

   always #4 clk = ~clk;

   miss_switch_ctrl u_miss_switch_ctrl (
      .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_tid(miss_tid),
      .fill_done(fill_done), .retire_valid(retire_valid), .retire_next_pc(retire_next_pc),
      .active_tid(active_tid), .flush(flush), .fetch_en(fetch_en),
      .pc_load(pc_load), .resume_pc(resume_pc));

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic tick;
      @(posedge clk);
      #2;
   endtask

   // behavioural reference: mode 0 running, 1 penalty, 2 idle
   int          m_act, m_mode, m_cnt;
   bit          m_pend, m_flush, m_load;
   bit          m_wait [N];
   logic [31:0] m_saved [N];
   logic [31:0] m_track;

   always @(posedge clk) begin
      bit ow [N];
      bit hit, sw, fnd;
      int tgt;
      if (!rst_n) begin
         m_act = 0; m_mode = 0; m_cnt = 0; m_pend = 0; m_flush = 0; m_load = 1;
         for (int t = 0; t < N; t++) begin
            m_wait[t]  = 0;
            m_saved[t] = BASE + STR * t;
         end
         m_track = BASE;
      end else begin
         ow  = m_wait;
         hit = miss_valid && (int'(miss_tid) == m_act) && !ow[m_act];
         sw  = (m_mode == 0 && hit) || (m_mode == 1 && m_cnt == 0 && (m_pend || hit));
         m_flush = 0;
         m_load  = 0;
         for (int t = 0; t < N; t++) if (fill_done[t]) m_wait[t] = 0;
         if (sw) begin
            m_wait[m_act]  = 1;
            m_saved[m_act] = m_track;
            fnd = 0;
            tgt = m_act;
            for (int k = 1; k < N; k++)
               if (!fnd && !ow[(m_act + k) % N]) begin fnd = 1; tgt = (m_act + k) % N; end
            m_act = tgt; m_track = m_saved[tgt];
            m_mode = 1; m_cnt = P - 1; m_pend = 0; m_flush = 1;
         end else if (m_mode == 0) begin
            if (retire_valid) m_track = retire_next_pc;
         end else if (m_mode == 1) begin
            if (m_cnt != 0) begin
               m_cnt--;
               m_pend = m_pend | hit;
            end else if (ow[m_act]) begin
               m_mode = 2;
            end else begin
               m_mode = 0; m_load = 1;
            end
         end else begin
            fnd = 0;
            for (int k = 1; k <= N; k++)
               if (!fnd && !ow[(m_act + k) % N]) begin
                  fnd = 1; m_act = (m_act + k) % N;
               end
            if (fnd) begin
               m_track = m_saved[m_act]; m_mode = 0; m_load = 1;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R2", "model active_tid", 64'(active_tid), 64'(m_act));
         chk("R2", "model flush", 64'(flush), 64'(m_flush));
         chk("R3", "model fetch_en", 64'(fetch_en), 64'(m_mode == 0));
         chk("R3", "model pc_load", 64'(pc_load), 64'(m_load));
         chk("R4", "model resume_pc", 64'(resume_pc), 64'(m_track));
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic count_penalty(input string req, input logic [31:0] exp_pc, input int exp_tid);
      int n;
      n = 1;
      tick;
      while (!fetch_en && n < 20) begin
         n++;
         tick;
      end
      chk(req, "penalty length", 64'(n), 64'(P));
      chk(req, "pc_load after penalty", 64'(pc_load), 64'd1);
      chk(req, "resume_pc after penalty", 64'(resume_pc), 64'(exp_pc));
      chk(req, "active after penalty", 64'(active_tid), 64'(exp_tid));
   endtask

   initial begin
      repeat (2) @(posedge clk);
      #2;
      chk("R1", "reset active_tid", 64'(active_tid), 64'd0);
      chk("R1", "reset fetch_en", 64'(fetch_en), 64'd1);
      chk("R1", "reset flush", 64'(flush), 64'd0);
      chk("R1", "reset pc_load", 64'(pc_load), 64'd1);
      chk("R1", "reset resume_pc", 64'(resume_pc), 64'(BASE));
      rst_n = 1'b1;
      tick;

      retire_valid = 1; retire_next_pc = 32'h1004; tick;
      retire_next_pc = 32'h1008; tick;
      retire_valid = 0;

      // foreign miss
      miss_valid = 1; miss_tid = 1; tick;
      miss_valid = 0;
      chk("R5", "no flush on foreign miss", 64'(flush), 64'd0);
      chk("R5", "still running thread 0", 64'(active_tid), 64'd0);

      // switch 0 -> 1, retire in switch cycle discarded
      miss_valid = 1; miss_tid = 0; retire_valid = 1; retire_next_pc = 32'h100C; tick;
      miss_valid = 0;
      chk("R2", "flush after miss", 64'(flush), 64'd1);
      chk("R2", "switched to thread 1", 64'(active_tid), 64'd1);
      chk("R2", "fetch off after miss", 64'(fetch_en), 64'd0);
      retire_next_pc = 32'hBAD0;
      count_penalty("R9", STR + BASE, 1);
      retire_valid = 0;

      retire_valid = 1; retire_next_pc = 32'h2004; tick;
      retire_valid = 0;
      fill_done = 2'b10; tick;
      fill_done = 2'b01; tick;
      fill_done = 2'b00;

      // switch 1 -> 0, thread 0 resumes at saved pc
      miss_valid = 1; miss_tid = 1; tick;
      miss_valid = 0;
      chk("R2", "flush 1->0", 64'(flush), 64'd1);
      count_penalty("R4", 32'h1008, 0);

      // both waiting -> idle
      miss_valid = 1; miss_tid = 0; tick;
      miss_valid = 0;
      chk("R7", "flush with no ready peer", 64'(flush), 64'd1);
      chk("R7", "active unchanged", 64'(active_tid), 64'd0);
      for (int i = 0; i < 10; i++) begin
         tick;
         chk("R6", "idle while all waiting", 64'(fetch_en), 64'd0);
      end
      fill_done = 2'b10; tick;
      fill_done = 2'b00;
      chk("R7", "fetch still off one cycle after fill", 64'(fetch_en), 64'd0);
      tick;
      chk("R7", "fetch on after fill", 64'(fetch_en), 64'd1);
      chk("R7", "returning thread active", 64'(active_tid), 64'd1);
      chk("R7", "resume pc of thread 1", 64'(resume_pc), 64'h2004);
      chk("R7", "pc_load on restart", 64'(pc_load), 64'd1);

      // miss held during penalty
      fill_done = 2'b01; tick;
      fill_done = 2'b00;
      miss_valid = 1; miss_tid = 1; tick;
      miss_valid = 0;
      chk("R8", "first flush", 64'(flush), 64'd1);
      chk("R8", "switched to thread 0", 64'(active_tid), 64'd0);
      miss_valid = 1; miss_tid = 0; tick;
      miss_valid = 0;
      tick;
      chk("R8", "no flush mid window", 64'(flush), 64'd0);
      tick;
      chk("R8", "no flush at window end", 64'(flush), 64'd0);
      tick;
      chk("R8", "held miss flushes", 64'(flush), 64'd1);
      chk("R8", "fetch stayed off", 64'(fetch_en), 64'd0);
      for (int i = 0; i < 6; i++) tick;
      chk("R8", "idle after held miss", 64'(fetch_en), 64'd0);
      fill_done = 2'b10; tick;
      fill_done = 2'b00; tick;
      chk("R8", "thread 1 restarts", 64'(active_tid), 64'd1);
      chk("R8", "thread 1 pc", 64'(resume_pc), 64'h2004);

      // round-order choice in idle
      miss_valid = 1; miss_tid = 1; tick;
      miss_valid = 0;
      chk("R10", "stays on thread 1", 64'(active_tid), 64'd1);
      for (int i = 0; i < 6; i++) tick;
      fill_done = 2'b11; tick;
      fill_done = 2'b00; tick;
      chk("R10", "wrap choice thread 0", 64'(active_tid), 64'd0);
      chk("R10", "thread 0 pc after held miss", 64'(resume_pc), 64'h1008);
      chk("R10", "fetch on", 64'(fetch_en), 64'd1);
      repeat (3) tick;

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule